// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block produces the bit-period enable for a serial communications interface shifter. It runs on the bus clock, which is one quarter of the core clock. A byte-wide rate register selects the divide ratio. That ratio is a base prescale of 1, 3, 4 or 13, multiplied by a fixed factor of 16 and then by a power of two from 2^0 to 2^7. The block counts bus-clock cycles and raises a single-cycle tick once per bit period. The shifter uses that tick as its enable.

Software writes the rate register through a simple write strobe and reads it back on a parallel output. Two test-mode bits are stored and read back but have no effect on the tick. The reset value depends on a bootstrap-mode input that is sampled while reset is asserted. In normal mode the register clears to zero, which gives the fastest rate. In bootstrap mode it presets to a slow rate of about 1200 baud, suitable for a loader.

Top module: `baud_rate_gen`

## Requirements
- R1: The prescale field, bits 5:4, selects a base of 1 (00), 3 (01), 4 (10) or 13 (11). The divisor is that base times 16, and any encoding outside the first three falls back to 13.
- R2: The rate field, bits 2:0, holds an exponent n, and the divisor is multiplied by 2^n.
- R3: `tick_o` is high for exactly one clock cycle, and consecutive ticks are exactly divisor cycles apart.
- R4: When reset is asserted with `boot_mode_i` low, the register reads 0x00 and the divisor is 16.
- R5: When reset is asserted with `boot_mode_i` high, the register reads 0x33, which selects prescale 13 and exponent 3, giving a divisor of 1664.
- R6: A register write restarts the count. The first tick comes exactly divisor-1 cycles after the clock edge that captures the write, and no tick occurs before it. Leaving reset behaves the same way.
- R7: A write stores bits 7 and 5:0 of `wr_data_i`, and bit 6 always reads 0.
- R8: The test bits, bit 7 and bit 3, are stored and read back but do not change the tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock (core clock / 4) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_mode_i | input | 1 | Bootstrap mode; selects the reset preset, held stable during reset |
| wr_en_i | input | 1 | Rate register write strobe |
| wr_data_i | input | 8 | Rate register write data |
| rd_data_o | output | 8 | Rate register readback |
| tick_o | output | 1 | One-cycle bit-period tick |

## Verification
The bench goes after the prescale decode for each of the four encodings. A swapped or truncated table would give periods of the wrong multiple of 16. It also checks the extreme exponents, where a counter that is too narrow would wrap early at the 26624-cycle setting. A write in the middle of a period must push the next tick out by a full new period; a design that does not restart would tick early. The bench also checks the bootstrap preset, the masked bit 6, and that the test bits leave the period unchanged, since an off-by-one decode would let them alter the rate.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned RATE_BITS  = 3;
  localparam int unsigned PRE_MULT   = 16;
  localparam int unsigned MAX_BASE   = 13;
  localparam int unsigned DIV_W      = $clog2(MAX_BASE * PRE_MULT) + (2 ** RATE_BITS) - 1 + 1;
  localparam logic [REG_W-1:0] RST_NORMAL = 8'h00;
  localparam logic [REG_W-1:0] RST_BOOT   = 8'h33;
  localparam logic [REG_W-1:0] WR_MASK    = 8'hBF;

  typedef enum logic [1:0] {
    PRE_DIV1  = 2'b00,
    PRE_DIV3  = 2'b01,
    PRE_DIV4  = 2'b10,
    PRE_DIV13 = 2'b11
  } prescale_e;

  typedef struct packed {
    logic                 test_clr;
    logic                 rsvd;
    prescale_e            prescale;
    logic                 test_chk;
    logic [RATE_BITS-1:0] rate;
  } baud_reg_t;
endpackage

// File: rtl/baud_reg.sv
module baud_reg
  import baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_mode_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output baud_reg_t        reg_o
);
  logic [REG_W-1:0] reg_q;

  // preset selected while reset is held; boot_mode_i must be stable then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reg_q <= boot_mode_i ? RST_BOOT : RST_NORMAL;
    else if (wr_en_i) reg_q <= wr_data_i & WR_MASK;
  end

  assign reg_o = baud_reg_t'(reg_q);
endmodule

// File: rtl/baud_div_calc.sv
module baud_div_calc
  import baud_pkg::*;
(
  input  baud_reg_t        reg_i,
  output logic [DIV_W-1:0] div_o
);
  logic [DIV_W-1:0] base;

  always_comb begin
    unique case (reg_i.prescale)
      PRE_DIV1: base = DIV_W'(1 * PRE_MULT);
      PRE_DIV3: base = DIV_W'(3 * PRE_MULT);
      PRE_DIV4: base = DIV_W'(4 * PRE_MULT);
      default:  base = DIV_W'(13 * PRE_MULT);
    endcase
  end

  assign div_o = base << reg_i.rate;
endmodule

// File: rtl/baud_tick_cnt.sv
module baud_tick_cnt
  import baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q >= div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (last)      cnt_q <= '0;
    else                cnt_q <= cnt_q + DIV_W'(1);
  end

  assign tick_o = last;
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_mode_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             tick_o
);
  baud_reg_t        reg_cur;
  logic [DIV_W-1:0] div;

  baud_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_mode_i (boot_mode_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .reg_o       (reg_cur)
  );

  baud_div_calc u_calc (
    .reg_i (reg_cur),
    .div_o (div)
  );

  baud_tick_cnt u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_en_i),
    .div_i     (div),
    .tick_o    (tick_o)
  );

  assign rd_data_o = REG_W'(reg_cur);
endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk
  import baud_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             tick_o
);
  logic [DIV_W-1:0] gap_q;
  logic [DIV_W-1:0] exp_div;
  logic [DIV_W-1:0] exp_base;

  always_comb begin
    case (rd_data_o[5:4])
      2'd0:    exp_base = DIV_W'(16);
      2'd1:    exp_base = DIV_W'(48);
      2'd2:    exp_base = DIV_W'(64);
      default: exp_base = DIV_W'(208);
    endcase
    exp_div = exp_base << rd_data_o[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (wr_en_i || tick_o) gap_q <= '0;
    else                        gap_q <= gap_q + DIV_W'(1);
  end

  assert_tick_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> gap_q == exp_div - DIV_W'(1));
  assert_no_early_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q < exp_div - DIV_W'(1)) |-> !tick_o);
  assert_tick_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tick_o);
  assert_wr_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == ($past(wr_data_i) & 8'hBF));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
  assert_bit6_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[6]);
endmodule

bind baud_rate_gen baud_rate_gen_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .tick_o    (tick_o)
);

// File: tb/test_baud_rate_gen.sv
module test_baud_rate_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       boot_mode_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       tick_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  baud_rate_gen i_baud_rate_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_mode_i (boot_mode_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .tick_o      (tick_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int exp_div(input logic [7:0] v);
    int b;
    case (v[5:4])
      2'd0: b = 1;
      2'd1: b = 3;
      2'd2: b = 4;
      default: b = 13;
    endcase
    return b * 16 * (1 << v[2:0]);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // cycles from current negedge until tick_o seen high
  task automatic wait_tick(output int c);
    c = 0;
    while (!tick_o && c < 40000) begin
      @(negedge clk_i);
      c++;
    end
  endtask

  // first tick after restart, its width, then one full period
  task automatic measure(input string req, input logic [7:0] v);
    int c;
    int d;
    d = exp_div(v);
    wait_tick(c);
    check({req, " first tick (R6)"}, c, d - 1);
    @(negedge clk_i);
    check({req, " tick width (R3)"}, int'(tick_o), 0);
    wait_tick(c);
    check({req, " period (R3)"}, c + 1, d);
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c;
    logic [7:0] v;
    void'($urandom(32'd1234));
    // R4 reset state
    #20;
    check("R4 reset value", rd_data_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    measure("R4 divisor 16", 8'h00);

    // R1 each prescale encoding
    wr(8'h10); measure("R1 pre 3", 8'h10);
    wr(8'h20); measure("R1 pre 4", 8'h20);
    wr(8'h30); measure("R1 pre 13", 8'h30);
    // R2 exponents
    wr(8'h07); measure("R2 exp 7", 8'h07);
    wr(8'h37); wait_tick(c); check("R2 max divisor", c, 26623);

    // R7 bit 6 masked, other bits stored
    wr(8'hFF);
    check("R7 readback FF", rd_data_o, 8'hBF);
    wr(8'h40);
    check("R7 readback 40", rd_data_o, 8'h00);
    // R8 test bits do not alter period
    wr(8'h88);
    check("R8 readback", rd_data_o, 8'h88);
    measure("R8 test bits", 8'h88);

    // R6 mid-period write restarts
    wr(8'h21);
    repeat (50) @(negedge clk_i);
    check("R6 no tick mid period", int'(tick_o), 0);
    wr(8'h21);
    measure("R6 restart", 8'h21);

    // random settings
    for (int i = 0; i < 10; i++) begin
      v = 8'($urandom);
      v[2:0] = v[2:0] & 3'b011;
      wr(v);
      check("R7 random readback", rd_data_o, v & 8'hBF);
      measure("R1 R2 random", v);
    end

    // R5 bootstrap preset
    @(negedge clk_i);
    rst_ni = 1'b0;
    boot_mode_i = 1'b1;
    #20;
    check("R5 boot value", rd_data_o, 8'h33);
    @(negedge clk_i);
    rst_ni = 1'b1;
    measure("R5 boot divisor", 8'h33);
    check("R5 boot period value", exp_div(8'h33), 1664);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule